// File: doc/BRIEF.md
# Bicolor Status LED Register Controller

This block is a small bank of byte-wide control registers for the front-panel indicator LEDs of a system board. Each register holds two 4-bit codes, and each code drives one LED. A bicolor LED can be off, steadily red or green, or blinking red or green at a slow (3 Hz) or fast (6 Hz) rate. A board build with an identification LED adds a blue LED. It has its own code in a reduced code set. A host writes and reads the codes through a plain synchronous port with an address, write data, a write strobe and registered read data.

One free-running divider, sized from the clock-frequency parameter, produces both blink phases. Every blinking LED on the board therefore changes state on the same edges. The `BOARD` parameter selects one of two fixed maps from codes to LEDs. Board 0 has a status LED, a power-supply LED and four fan LEDs. Board 1 has a status LED, one fan LED, two power-supply LEDs and the blue identification LED.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset every stored code is 0000, `rd_data` is 0x00 and every LED output is 0.
- R2: With BOARD=0, slot 0 takes bits [3:0] and slot 1 takes bits [7:4] of offset 0x20. Slots 2 and 3 take the low and high nibbles of 0x21, and slots 4 and 5 take the low and high nibbles of 0x22. `led_blue` stays 0.
- R3: With BOARD=1, slot 0 takes 0x20[3:0] and slot 1 takes 0x21[3:0]. Slots 2 and 3 take 0x23[3:0] and 0x23[7:4]. The blue LED takes 0x24[3:0]. Slots 4 and 5 stay 0. The nibbles 0x20[7:4], 0x21[7:4] and 0x24[7:4] are not stored and read as 0.
- R4: Bicolor code (bit3..bit0): 0101 red steady, 1101 green steady, 0110 red slow blink, 1110 green slow blink, 0111 red fast blink, 1111 green fast blink, 0000 off. Red and green of one slot are never lit together.
- R5: A bicolor code not listed in R4 leaves the LED off.
- R6: Blue code: 1101 steady, 1110 slow blink, 1111 fast blink. Every other value, including 0101, 0110 and 0111, leaves the blue LED off.
- R7: Blinks have 50% duty. The fast phase holds for CLK_HZ/12 cycles and the slow phase holds for CLK_HZ/6 cycles. Both phases start in the lit half when reset is released.
- R8: Every slow-phase change falls on a clock edge where the fast phase also changes. Register writes never restart the divider.
- R9: `rd_data` shows, one clock after the address is presented, the masked value stored at that offset. A read of the address being written in the same cycle returns the old value.
- R10: Offsets outside the mapped registers read as 0x00, and writes to them change no state.
- R11: A write changes the LED outputs right after the edge that stores it, with the phase in force at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Register offset for read and write |
| wr_en | input | 1 | Write strobe for `wr_data` at `addr` |
| wr_data | input | 8 | Byte holding two LED codes |
| rd_data | output | 8 | Registered read value of the offset |
| led_red | output | 6 | Red enable per bicolor slot |
| led_green | output | 6 | Green enable per bicolor slot |
| led_blue | output | 1 | Blue identification LED enable |

## Verification
Two events can land on the same clock edge. A host write can coincide with a blink-phase edge, and a write can coincide with a read of the same offset. The bench times a write so that it is stored on an edge where the divider wraps. It then checks that the new code appears at once with the freshly toggled phase and that the later blink timing keeps the phase reference taken before the write. For the second case it writes and addresses an offset in one cycle and expects the old byte on `rd_data`, then the new masked byte one cycle later.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;

  localparam int NIB_W      = 4;
  localparam int BYTE_W     = 2 * NIB_W;
  localparam int REG_COUNT  = 5;
  localparam int NIB_COUNT  = 2 * REG_COUNT;
  localparam int SLOT_COUNT = 6;

  typedef enum logic [1:0] {
    RATE_NONE,
    RATE_STEADY,
    RATE_SLOW,
    RATE_FAST
  } rate_e;

  typedef enum logic [1:0] {
    HUE_NONE,
    HUE_RED,
    HUE_GREEN,
    HUE_BLUE
  } hue_e;

  typedef struct packed {
    hue_e  hue;
    rate_e rate;
  } drive_t;

  // Nibble n sits in register n/2, high half when n is odd.
  function automatic bit nib_present(int board, int nib);
    if (board == 0) begin
      return nib < 6;
    end
    return (nib == 0) || (nib == 2) || (nib == 6) || (nib == 7) || (nib == 8);
  endfunction

  function automatic int slot_nib(int board, int slot);
    if (board == 0) begin
      return slot;
    end
    case (slot)
      0:       return 0;
      1:       return 2;
      2:       return 6;
      3:       return 7;
      default: return -1;
    endcase
  endfunction

  function automatic int blue_nib(int board);
    return (board == 1) ? 8 : -1;
  endfunction

endpackage

// File: rtl/led_reg_bank.sv
module led_reg_bank
  import led_ctrl_pkg::*;
#(
  parameter int BOARD  = 0,
  parameter int ADDR_W = 8,
  parameter int BASE   = 32'h20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_en,
  input  logic [BYTE_W-1:0]           wr_data,
  output logic [BYTE_W-1:0]           rd_data,
  output logic [NIB_COUNT*NIB_W-1:0]  nib_flat
);

  localparam int IDX_W = $clog2(REG_COUNT);

  logic [ADDR_W-1:0] offset;
  logic              hit;
  logic [IDX_W-1:0]  idx;

  assign offset = addr - ADDR_W'(BASE);
  assign hit    = (addr >= ADDR_W'(BASE)) && (offset < ADDR_W'(REG_COUNT));
  assign idx    = offset[IDX_W-1:0];

  for (genvar n = 0; n < NIB_COUNT; n++) begin : g_nib
    if (nib_present(BOARD, n)) begin : g_store
      logic [NIB_W-1:0] code_q;
      logic [NIB_W-1:0] code_d;
      logic             code_en;

      always_comb begin
        code_en = wr_en && hit && (idx == IDX_W'(n / 2));
        code_d  = wr_data[(n % 2) * NIB_W +: NIB_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_q <= '0;
        end else if (code_en) begin
          code_q <= code_d;
        end
      end

      assign nib_flat[n * NIB_W +: NIB_W] = code_q;
    end else begin : g_absent
      assign nib_flat[n * NIB_W +: NIB_W] = '0;
    end
  end

  logic [BYTE_W-1:0] rd_d;
  logic [BYTE_W-1:0] rd_q;

  always_comb begin
    rd_d = '0;
    for (int r = 0; r < REG_COUNT; r++) begin
      if (hit && (idx == IDX_W'(r))) begin
        rd_d = nib_flat[r * BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ph_fast,
  output logic ph_slow,
  output logic [((CLK_HZ / 12) > 1 ? $clog2(CLK_HZ / 12) : 1)-1:0] cnt
);

  localparam int HALF_FAST = (CLK_HZ / 12) > 0 ? (CLK_HZ / 12) : 1;
  localparam int CNT_W     = (HALF_FAST > 1) ? $clog2(HALF_FAST) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;
  logic             fast_q;
  logic             fast_d;
  logic             slow_q;
  logic             slow_d;
  logic             slow_en;

  always_comb begin
    wrap    = (cnt_q == CNT_W'(HALF_FAST - 1));
    cnt_d   = wrap ? '0 : cnt_q + CNT_W'(1);
    fast_d  = ~fast_q;
    // slow phase flips on every second fast flip, when fast goes low to high
    slow_en = wrap && !fast_q;
    slow_d  = ~slow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fast_q <= 1'b1;
      slow_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      if (wrap) begin
        fast_q <= fast_d;
      end
      if (slow_en) begin
        slow_q <= slow_d;
      end
    end
  end

  assign ph_fast = fast_q;
  assign ph_slow = slow_q;
  assign cnt     = cnt_q;

endmodule

// File: rtl/led_code_dec.sv
module led_code_dec
  import led_ctrl_pkg::*;
#(
  parameter bit BLUE_SET = 1'b0
) (
  input  logic [NIB_W-1:0] code,
  input  logic             ph_fast,
  input  logic             ph_slow,
  output hue_e             hue,
  output logic             lit
);

  drive_t drv;

  if (BLUE_SET) begin : g_blue
    always_comb begin
      case (code)
        4'b1101: drv = '{hue: HUE_BLUE, rate: RATE_STEADY};
        4'b1110: drv = '{hue: HUE_BLUE, rate: RATE_SLOW};
        4'b1111: drv = '{hue: HUE_BLUE, rate: RATE_FAST};
        default: drv = '{hue: HUE_NONE, rate: RATE_NONE};
      endcase
    end
  end else begin : g_bicolor
    always_comb begin
      case (code)
        4'b0101: drv = '{hue: HUE_RED,   rate: RATE_STEADY};
        4'b1101: drv = '{hue: HUE_GREEN, rate: RATE_STEADY};
        4'b0110: drv = '{hue: HUE_RED,   rate: RATE_SLOW};
        4'b1110: drv = '{hue: HUE_GREEN, rate: RATE_SLOW};
        4'b0111: drv = '{hue: HUE_RED,   rate: RATE_FAST};
        4'b1111: drv = '{hue: HUE_GREEN, rate: RATE_FAST};
        default: drv = '{hue: HUE_NONE,  rate: RATE_NONE};
      endcase
    end
  end

  always_comb begin
    hue = drv.hue;
    case (drv.rate)
      RATE_STEADY: lit = 1'b1;
      RATE_SLOW:   lit = ph_slow;
      RATE_FAST:   lit = ph_fast;
      default:     lit = 1'b0;
    endcase
  end

endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_ctrl_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BOARD  = 0,
  parameter int ADDR_W = 8,
  parameter int BASE   = 32'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [5:0]        led_red,
  output logic [5:0]        led_green,
  output logic              led_blue
);

  localparam int HALF_FAST = (CLK_HZ / 12) > 0 ? (CLK_HZ / 12) : 1;
  localparam int CNT_W     = (HALF_FAST > 1) ? $clog2(HALF_FAST) : 1;
  localparam int BLUE_N    = blue_nib(BOARD);

  // asynchronous assertion, release aligned to clk
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic [NIB_COUNT*NIB_W-1:0] nib_flat;
  logic                       ph_fast;
  logic                       ph_slow;
  logic [CNT_W-1:0]           blink_cnt;

  led_reg_bank #(
    .BOARD  (BOARD),
    .ADDR_W (ADDR_W),
    .BASE   (BASE)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .nib_flat (nib_flat)
  );

  led_blink_timer #(
    .CLK_HZ (CLK_HZ)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ph_fast (ph_fast),
    .ph_slow (ph_slow),
    .cnt     (blink_cnt)
  );

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
    localparam int SN = slot_nib(BOARD, s);
    if (SN >= 0) begin : g_used
      hue_e slot_hue;
      logic slot_lit;

      led_code_dec #(
        .BLUE_SET (1'b0)
      ) u_dec (
        .code    (nib_flat[SN * NIB_W +: NIB_W]),
        .ph_fast (ph_fast),
        .ph_slow (ph_slow),
        .hue     (slot_hue),
        .lit     (slot_lit)
      );

      assign led_red[s]   = slot_lit && (slot_hue == HUE_RED);
      assign led_green[s] = slot_lit && (slot_hue == HUE_GREEN);
    end else begin : g_unused
      assign led_red[s]   = 1'b0;
      assign led_green[s] = 1'b0;
    end
  end

  if (BLUE_N >= 0) begin : g_blue
    hue_e id_hue;
    logic id_lit;

    led_code_dec #(
      .BLUE_SET (1'b1)
    ) u_dec (
      .code    (nib_flat[BLUE_N * NIB_W +: NIB_W]),
      .ph_fast (ph_fast),
      .ph_slow (ph_slow),
      .hue     (id_hue),
      .lit     (id_lit)
    );

    assign led_blue = id_lit && (id_hue == HUE_BLUE);
  end else begin : g_no_blue
    assign led_blue = 1'b0;
  end

endmodule

// File: rtl/led_blink_ctrl_chk.sv
module led_blink_ctrl_chk
  import led_ctrl_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BOARD  = 0,
  parameter int ADDR_W = 8,
  parameter int BASE   = 32'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic [5:0]        led_red,
  input logic [5:0]        led_green,
  input logic              ph_fast,
  input logic              ph_slow,
  input logic [((CLK_HZ / 12) > 1 ? $clog2(CLK_HZ / 12) : 1)-1:0] blink_cnt
);

  localparam int HALF_FAST = (CLK_HZ / 12) > 0 ? (CLK_HZ / 12) : 1;
  localparam int CNT_W     = (HALF_FAST > 1) ? $clog2(HALF_FAST) : 1;

  function automatic logic [7:0] byte_mask(logic [ADDR_W-1:0] a);
    logic [7:0] m;
    m = 8'h00;
    for (int r = 0; r < REG_COUNT; r++) begin
      if (a == ADDR_W'(BASE + r)) begin
        m[3:0] = nib_present(BOARD, 2 * r)     ? 4'hF : 4'h0;
        m[7:4] = nib_present(BOARD, 2 * r + 1) ? 4'hF : 4'h0;
      end
    end
    return m;
  endfunction

  // R4
  one_hue_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (led_red & led_green) == 6'b0);

  // R7
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blink_cnt <= CNT_W'(HALF_FAST - 1));

  // R7
  fast_flip_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ph_fast) |-> $past(blink_cnt) == CNT_W'(HALF_FAST - 1));

  // R8
  slow_with_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ph_slow) |-> !$stable(ph_fast));

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mask(addr) == 8'h00) |=> rd_data == 8'h00);

  // R9
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !wr_en && addr == $past(addr))
      |=> rd_data == ($past(wr_data, 2) & byte_mask($past(addr))));

endmodule

bind led_blink_ctrl led_blink_ctrl_chk #(
  .CLK_HZ (CLK_HZ),
  .BOARD  (BOARD),
  .ADDR_W (ADDR_W),
  .BASE   (BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .addr      (addr),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .led_red   (led_red),
  .led_green (led_green),
  .ph_fast   (ph_fast),
  .ph_slow   (ph_slow),
  .blink_cnt (blink_cnt)
);

// File: tb/sim_led_blink_ctrl.sv
`timescale 1ns/1ps
module sim_led_blink_ctrl;

  localparam int CLK_HZ = 1200;
  localparam int HALF   = CLK_HZ / 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd0, rd1;
  logic [5:0] red0, green0, red1, green1;
  logic       blue0, blue1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int c0     = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  led_blink_ctrl #(.CLK_HZ(CLK_HZ), .BOARD(0)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd0), .led_red(red0), .led_green(green0), .led_blue(blue0));

  led_blink_ctrl #(.CLK_HZ(CLK_HZ), .BOARD(1)) u1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd1), .led_red(red1), .led_green(green1), .led_blue(blue1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // register masks per board, from R2 and R3
  function automatic logic [7:0] mask0(input logic [7:0] a);
    return (a >= 8'h20 && a <= 8'h22) ? 8'hFF : 8'h00;
  endfunction

  function automatic logic [7:0] mask1(input logic [7:0] a);
    case (a)
      8'h20, 8'h21, 8'h24: return 8'h0F;
      8'h23:               return 8'hFF;
      default:             return 8'h00;
    endcase
  endfunction

  // {red, green} for a bicolor code, from R4 and R5
  function automatic logic [1:0] bi(input logic [3:0] c, input logic f, input logic s);
    case (c)
      4'h5: return 2'b10;
      4'hD: return 2'b01;
      4'h6: return {s, 1'b0};
      4'hE: return {1'b0, s};
      4'h7: return {f, 1'b0};
      4'hF: return {1'b0, f};
      default: return 2'b00;
    endcase
  endfunction

  // blue from R6
  function automatic logic bl(input logic [3:0] c, input logic f, input logic s);
    case (c)
      4'hD: return 1'b1;
      4'hE: return s;
      4'hF: return f;
      default: return 1'b0;
    endcase
  endfunction

  // phase model from R7 and R8, anchored at the first fast fall (cycle c0)
  function automatic logic [1:0] phase(input int c);
    int m, idx;
    m   = c - c0 + HALF;
    idx = m / HALF;
    return {(idx % 2) == 0, ((idx / 2) % 2) == 0};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] e0, input logic [7:0] e1, input string req);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    check(req, {24'h0, rd0}, {24'h0, e0});
    check(req, {24'h0, rd1}, {24'h0, e1});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [1:0] p;
    logic [12:0] e0v, e1v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 leds", {19'h0, red0, green0, blue0}, 32'h0);
    check("R1 leds", {19'h0, red1, green1, blue1}, 32'h0);
    for (int a = 8'h20; a <= 8'h24; a++) rd_check(8'(a), 8'h00, 8'h00, "R1 regs");

    // R7: fast green on slot 0, starts lit, find first fall
    wr(8'h20, 8'h0F);
    check("R7 initial lit phase", {31'h0, green0[0]}, 32'h1);
    c0 = -1;
    for (int i = 0; i < 4 * HALF && c0 < 0; i++) begin
      @(negedge clk);
      if (green0[0] == 1'b0) c0 = cyc;
    end
    check("R7 fast phase falls", {31'h0, c0 >= 0}, 32'h1);

    // R9 R10 R2 R3: write every offset, then read every offset
    for (int a = 0; a < 256; a++) wr(8'(a), 8'(a) ^ 8'hA5);
    for (int a = 0; a < 256; a++) begin
      logic [7:0] v;
      v = 8'(a) ^ 8'hA5;
      rd_check(8'(a), v & mask0(8'(a)), v & mask1(8'(a)), "R9 R10 R2 R3 readback");
    end

    // R9: write and read same offset in one cycle
    @(negedge clk);
    addr = 8'h21; wr_en = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 old value during write", {24'h0, rd0}, {24'h0, 8'h21 ^ 8'hA5});
    @(negedge clk);
    check("R9 new value next cycle", {24'h0, rd0}, 32'h3C);
    check("R9 new value masked", {24'h0, rd1}, 32'h0C);

    // R11 R8: write stored on a divider wrap edge
    while (((cyc + 1 - c0) % HALF) != 0) @(negedge clk);
    addr = 8'h20; wr_en = 1'b1; wr_data = 8'h07;
    @(negedge clk);
    wr_en = 1'b0;
    p = phase(cyc);
    check("R11 red fast at wrap edge", {30'h0, red0[0], green0[0]}, {30'h0, p[1], 1'b0});
    check("R11 high nibble cleared", {30'h0, red0[1], green0[1]}, 32'h0);

    // R4 R5 R6 R7 R8: sweep every code over all slots
    for (int c = 0; c < 16; c++) begin
      for (int a = 8'h20; a <= 8'h24; a++) wr(8'(a), {4'(c), 4'(c)});
      for (int k = 0; k < 450; k++) begin
        logic [1:0] b;
        @(negedge clk);
        p = phase(cyc);
        b = bi(4'(c), p[1], p[0]);
        e0v = {{6{b[1]}}, {6{b[0]}}, 1'b0};
        e1v = {2'b00, {4{b[1]}}, 2'b00, {4{b[0]}}, bl(4'(c), p[1], p[0])};
        check("R2 R4 R5 R7 R8 board0", {19'h0, red0, green0, blue0}, {19'h0, e0v});
        check("R3 R4 R5 R6 R7 R8 board1", {19'h0, red1, green1, blue1}, {19'h0, e1v});
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule